// File: doc/BRIEF.md
# Cache Capacity Allocation Controller

This block holds one capacity block mask per resource-control ID (RCID). When code/data splitting is built in, each RCID has two masks: a data half and a code half. Software reaches the block through a small 32-bit register bus that uses naturally aligned word accesses. To change an entry, software first writes a mask into a staging register. It then writes an operation code, an RCID and an access type into the control word. The block runs the operation over a fixed number of cycles. While it runs, a busy flag is set. When it ends, the block reports the outcome as a status code.

The store operation copies the staging register into the selected table entry. The load operation copies the selected entry back into the staging register, where software can read it. When splitting is built out, the access-type field always reads as zero and a single mask serves both halves.

Each bus access completes in the cycle it is presented. There is no back-pressure: reads return data combinationally from the current address, and writes take effect at the next clock edge. The one exception is that writes to the control word or the staging register are dropped while an operation is busy.

Top module: `capalloc_ctrl`

## Requirements
- R1: After reset, every table entry is all ones across NCBLKS bits. The status code (byte offset 0x1C, bits 6:0) is 0, BUSY (offset 0x1C, bit 7) is 0, the control word at 0x18 is 0 and the staging register at 0x20 is 0.
- R2: The word at offset 0x00 reads {8'h00, NCBLKS[15:0], major[3:0], minor[3:0]}. The word at 0x04 reads 0.
- R3: A write to 0x20 keeps only bits NCBLKS-1:0, and the bits above NCBLKS read as 0. The word at 0x24 reads 0.
- R4: A write to 0x18 with a nonzero operation code in bits 4:0 clears the status to 0. It then holds BUSY at 1 for exactly BUSY_CYCLES cycles, after which BUSY returns to 0 and the status is set.
- R5: Operation code 1 stores the staging register into the entry named by RCID (bits 19:8) and AT (bits 7:5). Operation code 2 copies that entry into the staging register. Both finish with status 1.
- R6: Operation code 0 updates the control fields only. It does not set BUSY, does not change the status and does not touch the table.
- R7: Errors are checked in priority order. An operation code above 2 ends with status 2. Otherwise, an RCID at or above NUM_RCID ends with status 3. Otherwise, an AT above 1 (only when splitting is built in) ends with status 4. None of these changes the table or the staging register.
- R8: With splitting built in, the AT value written is kept and read back. AT 0 (data) and AT 1 (code) address independent masks.
- R9: With splitting built out, AT reads back as 0, and a store or load with any AT uses the single shared mask of that RCID.
- R10: While BUSY is 1, writes to 0x18 and 0x20 are ignored. Writes to 0x1C never change the status or BUSY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte address; bits 1:0 ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
Some properties are checked by assertions on every cycle:
- the status stays 0 whenever BUSY is set;
- BUSY only rises after an accepted operation;
- the control fields and the staging register hold still while BUSY is set;
- a store is readable from its entry in the cycle after it commits, and a committed operation always leaves status 1 with BUSY clear.

Other behaviour can only be shown by the bench scenarios: the exact busy length, the error priority, the independence of the data and code halves, the shared mask in the unsplit variant, and the table staying untouched after rejected operations. The bench shows these by driving the block and reading its registers back.

// File: rtl/capalloc_pkg.sv
package capalloc_pkg;

  localparam logic [5:0] OFF_CAP_LO  = 6'h00;
  localparam logic [5:0] OFF_CAP_HI  = 6'h04;
  localparam logic [5:0] OFF_CTL_LO  = 6'h18;
  localparam logic [5:0] OFF_CTL_HI  = 6'h1C;
  localparam logic [5:0] OFF_MASK_LO = 6'h20;
  localparam logic [5:0] OFF_MASK_HI = 6'h24;

  localparam logic [4:0] OP_NONE  = 5'd0;
  localparam logic [4:0] OP_STORE = 5'd1;
  localparam logic [4:0] OP_LOAD  = 5'd2;

  typedef enum logic [6:0] {
    ST_IDLE     = 7'd0,
    ST_OK       = 7'd1,
    ST_BAD_OP   = 7'd2,
    ST_BAD_RCID = 7'd3,
    ST_BAD_AT   = 7'd4
  } status_e;

  // Field order follows the control word: op in 4:0, at in 7:5, rcid in 19:8
  typedef struct packed {
    logic [11:0] rcid;
    logic [2:0]  at;
    logic [4:0]  op;
  } ctl_t;

endpackage

// File: rtl/capalloc_table.sv
module capalloc_table
  import capalloc_pkg::*;
#(
  parameter int NUM_RCID = 16,
  parameter int NCBLKS   = 16,
  parameter bit SPLIT    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [11:0]       rcid,
  input  logic [2:0]        at,
  input  logic [NCBLKS-1:0] wmask,
  output logic [NCBLKS-1:0] rmask
);

  localparam int HALVES  = SPLIT ? 2 : 1;
  localparam int ENTRIES = NUM_RCID * HALVES;
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [NCBLKS-1:0] mem [ENTRIES];
  logic [12:0]       full_idx;
  logic [IW-1:0]     idx;
  logic              inrange;

  generate
    if (SPLIT) begin : g_split
      assign full_idx = {rcid, at[0]};
    end else begin : g_shared
      assign full_idx = {1'b0, rcid};
    end
  endgenerate

  assign idx     = full_idx[IW-1:0];
  assign inrange = full_idx < 13'(ENTRIES);
  assign rmask   = inrange ? mem[idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '1;
    end else if (we && inrange) begin
      mem[idx] <= wmask;
    end
  end

  // R5: a committed store is visible at its entry in the next cycle
  a_r5_store_readback: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rmask == $past(wmask));

endmodule

// File: rtl/capalloc_seq.sv
module capalloc_seq
  import capalloc_pkg::*;
#(
  parameter int NUM_RCID    = 16,
  parameter bit SPLIT       = 1'b1,
  parameter int BUSY_CYCLES = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  ctl_t    ctl,
  output logic    busy,
  output status_e status,
  output logic    commit_store,
  output logic    commit_load
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          last;
  status_e       verdict;

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CW'(1));

  always_comb begin
    if (ctl.op > OP_LOAD)                        verdict = ST_BAD_OP;
    else if ({1'b0, ctl.rcid} >= 13'(NUM_RCID))  verdict = ST_BAD_RCID;
    else if (SPLIT && (ctl.at > 3'd1))           verdict = ST_BAD_AT;
    else                                         verdict = ST_OK;
  end

  assign commit_store = last && (verdict == ST_OK) && (ctl.op == OP_STORE);
  assign commit_load  = last && (verdict == ST_OK) && (ctl.op == OP_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      status <= ST_IDLE;
    end else if (last) begin
      cnt_q  <= '0;
      status <= verdict;
    end else if (busy) begin
      cnt_q  <= cnt_q - CW'(1);
    end else if (start) begin
      cnt_q  <= CW'(BUSY_CYCLES);
      status <= ST_IDLE;
    end
  end

  // R4: status reads 0 for the whole busy window
  a_r4_status_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status == ST_IDLE);

  // R4: busy only begins after an accepted operation
  a_r4_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R5: a commit always ends the operation with success
  a_r5_commit_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_store || commit_load) |=> (status == ST_OK) && !busy);

endmodule

// File: rtl/capalloc_regs.sv
module capalloc_regs
  import capalloc_pkg::*;
#(
  parameter int NCBLKS    = 16,
  parameter bit SPLIT     = 1'b1,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  status_e           status,
  input  logic              load_en,
  input  logic [NCBLKS-1:0] load_mask,
  output ctl_t              ctl,
  output logic              start,
  output logic [NCBLKS-1:0] stage
);

  localparam logic [15:0] NCB_FIELD = 16'(NCBLKS);
  localparam logic [3:0]  VMAJ      = 4'(VER_MAJOR);
  localparam logic [3:0]  VMIN      = 4'(VER_MINOR);

  logic [5:0] word;
  logic       wr;
  logic [2:0] at_in;

  assign word = {reg_addr[5:2], 2'b00};
  assign wr   = reg_en && reg_we && !busy;

  generate
    if (SPLIT) begin : g_at_kept
      assign at_in = reg_wdata[7:5];
    end else begin : g_at_zero
      assign at_in = 3'd0;
    end
  endgenerate

  assign start = wr && (word == OFF_CTL_LO) && (reg_wdata[4:0] != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr && (word == OFF_CTL_LO)) begin
      ctl.op   <= reg_wdata[4:0];
      ctl.at   <= at_in;
      ctl.rcid <= reg_wdata[19:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else if (load_en) begin
      stage <= load_mask;
    end else if (wr && (word == OFF_MASK_LO)) begin
      stage <= reg_wdata[NCBLKS-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (word)
      OFF_CAP_LO:  reg_rdata = {8'h00, NCB_FIELD, VMAJ, VMIN};
      OFF_CTL_LO:  reg_rdata = {12'h000, ctl};
      OFF_CTL_HI:  reg_rdata = {24'h0, busy, 7'(status)};
      OFF_MASK_LO: reg_rdata[NCBLKS-1:0] = stage;
      default:     reg_rdata = '0;
    endcase
  end

  // R10: control fields hold while an operation runs
  a_r10_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctl));

  // R10: staging register holds while an operation runs
  a_r10_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(stage));

endmodule

// File: rtl/capalloc_ctrl.sv
module capalloc_ctrl
  import capalloc_pkg::*;
#(
  parameter int NCBLKS      = 16,
  parameter int NUM_RCID    = 16,
  parameter bit SPLIT       = 1'b1,
  parameter int BUSY_CYCLES = 4,
  parameter int VER_MAJOR   = 1,
  parameter int VER_MINOR   = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);

  ctl_t              ctl;
  logic              start;
  logic              busy;
  status_e           status;
  logic              commit_store;
  logic              commit_load;
  logic [NCBLKS-1:0] stage;
  logic [NCBLKS-1:0] rmask;

  capalloc_regs #(
    .NCBLKS(NCBLKS), .SPLIT(SPLIT), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .status(status), .load_en(commit_load), .load_mask(rmask),
    .ctl(ctl), .start(start), .stage(stage)
  );

  capalloc_seq #(
    .NUM_RCID(NUM_RCID), .SPLIT(SPLIT), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl(ctl), .busy(busy),
    .status(status), .commit_store(commit_store), .commit_load(commit_load)
  );

  capalloc_table #(
    .NUM_RCID(NUM_RCID), .NCBLKS(NCBLKS), .SPLIT(SPLIT)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .we(commit_store), .rcid(ctl.rcid),
    .at(ctl.at), .wmask(stage), .rmask(rmask)
  );

endmodule

// File: tb/capalloc_ctrl_tb.sv
`timescale 1ns/1ps
module capalloc_ctrl_tb;

  localparam int BUSY = 4;
  localparam int NR   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = 6'h1C;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_ns;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  capalloc_ctrl #(.SPLIT(1'b1), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata));

  capalloc_ctrl #(.SPLIT(1'b0), .BUSY_CYCLES(BUSY)) u_dut_ns (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_ns));

  // Behavioural reference model of the split variant
  int          m_cnt;
  int          m_status;
  int          m_stage;
  int          m_op, m_at, m_rcid;
  int          tbl [0:2*NR-1];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_status = 0; m_stage = 0; m_op = 0; m_at = 0; m_rcid = 0;
      for (int i = 0; i < 2*NR; i++) tbl[i] = 32'hFFFF;
    end else if (m_cnt > 0) begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) begin
        if (m_op > 2) m_status = 2;
        else if (m_rcid >= NR) m_status = 3;
        else if (m_at > 1) m_status = 4;
        else begin
          m_status = 1;
          if (m_op == 1) tbl[m_rcid*2+m_at] = m_stage;
          else m_stage = tbl[m_rcid*2+m_at];
        end
      end
    end else if (reg_en && reg_we) begin
      if ({reg_addr[5:2], 2'b00} == 6'h18) begin
        m_op = int'(reg_wdata[4:0]); m_at = int'(reg_wdata[7:5]);
        m_rcid = int'(reg_wdata[19:8]);
        if (m_op != 0) begin m_status = 0; m_cnt = BUSY; end
      end else if ({reg_addr[5:2], 2'b00} == 6'h20) begin
        m_stage = int'(reg_wdata[15:0]);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison of BUSY/status against the model (R4, R7)
  always @(negedge clk) begin
    if (rst_n && !reg_en && reg_addr == 6'h1C)
      chk(rdata == {24'h0, 1'(m_cnt > 0), 7'(m_status)}, "R4/R7 model",
          int'(rdata), (m_cnt > 0 ? 128 : 0) + m_status);
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_en = 1'b0; reg_we = 1'b0; reg_addr = 6'h1C;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic [31:0] dn);
    @(posedge clk); #1;
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    d = rdata; dn = rdata_ns;
    #1; reg_en = 1'b0; reg_addr = 6'h1C;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_cnt > 0) @(negedge clk);
  endtask

  task automatic op(input int code, input int at, input int rcid);
    wr(6'h18, {12'h0, 12'(rcid), 3'(at), 5'(code)});
    wait_idle();
  endtask

  initial begin : watchdog
    #1000000;
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d, dn;
    int n;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(6'h1C, d, dn); chk(d == 0, "R1 ctl hi", d, 0);
    rd(6'h18, d, dn); chk(d == 0, "R1 ctl lo", d, 0);
    rd(6'h20, d, dn); chk(d == 0, "R1 stage", d, 0);
    // R2 capabilities
    rd(6'h00, d, dn); chk(d == 32'h0000_1010, "R2 cap lo", d, 32'h1010);
    rd(6'h04, d, dn); chk(d == 0, "R2 cap hi", d, 0);
    // R1 entries reset to all ones
    op(2, 0, 3);
    rd(6'h20, d, dn); chk(d == 32'hFFFF, "R1 entry ones", d, 32'hFFFF);
    // R3 mask width
    wr(6'h20, 32'hFFFF_1234);
    rd(6'h20, d, dn); chk(d == 32'h1234, "R3 mask trunc", d, 32'h1234);
    rd(6'h24, d, dn); chk(d == 0, "R3 mask hi", d, 0);
    // R4 busy length
    wr(6'h18, 32'h0000_0301);
    n = 0;
    @(negedge clk);
    while (rdata[7]) begin n++; @(negedge clk); end
    chk(n == BUSY, "R4 busy cycles", n, BUSY);
    rd(6'h1C, d, dn); chk(d == 1, "R4 status ok", d, 1);
    // R5 load back
    wr(6'h20, 32'h0);
    op(2, 0, 3);
    rd(6'h20, d, dn); chk(d == 32'h1234, "R5 store/load", d, 32'h1234);
    // R6 op 0 and R8/R9 AT readback
    wr(6'h18, 32'h0000_0020);
    rd(6'h1C, d, dn); chk(d == 1, "R6 op0 no busy/status", d, 1);
    rd(6'h18, d, dn);
    chk(d == 32'h20, "R8 at kept", d, 32'h20);
    chk(dn == 32'h0, "R9 at zero", dn, 0);
    op(2, 0, 3);
    rd(6'h20, d, dn); chk(d == 32'h1234, "R6 table untouched", d, 32'h1234);
    // R8 halves independent, R9 shared
    wr(6'h20, 32'h00AA); op(1, 1, 7);
    wr(6'h20, 32'h0055); op(1, 0, 7);
    wr(6'h20, 32'h0);    op(2, 1, 7);
    rd(6'h20, d, dn);
    chk(d == 32'hAA, "R8 code half", d, 32'hAA);
    chk(dn == 32'h55, "R9 shared mask", dn, 32'h55);
    op(2, 0, 7);
    rd(6'h20, d, dn); chk(d == 32'h55, "R8 data half", d, 32'h55);
    // R7 errors
    wr(6'h20, 32'h0F0F);
    op(5, 0, 1);
    rd(6'h1C, d, dn); chk(d == 2, "R7 bad op", d, 2);
    op(1, 0, NR);
    rd(6'h1C, d, dn); chk(d == 3, "R7 bad rcid", d, 3);
    op(1, 2, 2);
    rd(6'h1C, d, dn); chk(d == 4, "R7 bad at", d, 4);
    op(9, 2, NR);
    rd(6'h1C, d, dn); chk(d == 2, "R7 priority", d, 2);
    rd(6'h20, d, dn); chk(d == 32'h0F0F, "R7 stage kept", d, 32'h0F0F);
    op(2, 0, 0);
    rd(6'h20, d, dn); chk(d == 32'hFFFF, "R7 no alias rcid", d, 32'hFFFF);
    op(2, 0, 2);
    rd(6'h20, d, dn); chk(d == 32'hFFFF, "R7 no alias at", d, 32'hFFFF);
    // R10 writes while busy ignored
    wr(6'h18, 32'h0000_0702);
    wr(6'h20, 32'h3333);
    wr(6'h18, 32'h0000_0101);
    wait_idle();
    rd(6'h20, d, dn); chk(d == 32'h55, "R10 mask ignored", d, 32'h55);
    rd(6'h18, d, dn); chk(d == 32'h702, "R10 ctl ignored", d, 32'h702);
    wr(6'h1C, 32'hFFFF_FFFF);
    rd(6'h1C, d, dn); chk(d == 1, "R10 status read-only", d, 1);

    repeat (3) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule